// File: doc/BRIEF.md
# 1-Wire Bus Master Sequencer

This block is a self-timed master for a single-wire, open-drain sensor and memory bus. A host writes one command at a time: a bus reset, a single write slot, a single read slot, or eight slots that write or read a byte. The block then produces the whole waveform by itself. It drives an open-drain pulldown enable and a pullup-transistor enable, samples the returned line level and reports the result in flags and a read-data register. A busy flag stays high until the last recovery interval has run out.

All intervals count whole ticks of one shared time base. One tick is `CLK_PER_TICK` system clocks, which is 0.25 µs at the default setting. Two speed profiles, standard and overdrive, choose the tick counts for every interval. The speed, active-pullup and strong-pullup selections are captured when a command is accepted. The pullup transistor has two uses. As an active pullup it speeds up each rising edge for a short window. As a strong pullup it stays on after a command completes, together with an active-low enable for an external switch, until the next command is accepted.

Top module: `ow_master`

## Requirements
- R1: After reset: pd_en=0, pu_en=0, spu_n=1, busy=0, presence=0, short_det=0, rd_bit=0, rd_byte=0.
- R2: A reset command drives pd_en for 2400 ticks (288 at overdrive), then releases the line for 2336 ticks (296 at overdrive). busy is high from the clock after acceptance until that high phase ends.
- R3: presence and short_det are cleared when a reset command is accepted. presence becomes 1 if line_in is low 280 ticks after release (30 at overdrive).
- R4: short_det becomes 1 if line_in is low 32 ticks after the reset release (3 at overdrive).
- R5: A bit slot lasts 277 ticks (42 at overdrive). It starts with pd_en high for 32 ticks (4) for a one or a read, or 256 ticks (30) for a zero. line_in is sampled 56 ticks (6) after the slot starts, and the sampled value goes to rd_bit.
- R6: The byte commands run 8 slots, least significant bit first. The sample of slot k lands in rd_byte bit k, so writing a byte leaves that byte in rd_byte. rd_bit holds the sample of the last slot.
- R7: If cfg_active_pu was 1 at acceptance, pu_en is high for 10 ticks (2 at overdrive) starting at every clock where pd_en falls. pu_en and pd_en are never high together.
- R8: If cfg_strong_pu was 1 at acceptance, pu_en=1 and spu_n=0 from the clock where busy falls. Both hold until the next valid command is accepted.
- R9: A command is accepted only when cmd_valid=1 and busy=0. Commands presented while busy is high have no effect.
- R10: cmd_op encoding: 0 bus reset, 1 write bit (cmd_data[0]), 2 read bit, 3 write byte (cmd_data), 4 read byte. The codes 5 to 7 are ignored and leave a held strong pullup in place.
- R11: cfg_overdrive=1 at acceptance selects the overdrive tick counts. Every interval is its tick count times CLK_PER_TICK clocks, measured from the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 8 | Write data (bit 0 for a single slot) |
| cfg_overdrive | input | 1 | Overdrive speed select |
| cfg_active_pu | input | 1 | Active pullup on rising edges |
| cfg_strong_pu | input | 1 | Arm strong pullup after the command |
| line_in | input | 1 | Sampled bus level |
| pd_en | output | 1 | Open-drain pulldown enable |
| pu_en | output | 1 | Pullup transistor enable |
| spu_n | output | 1 | Active-low external strong-pullup switch |
| busy | output | 1 | Command in progress |
| presence | output | 1 | Presence seen on last reset |
| short_det | output | 1 | Shorted line seen on last reset |
| rd_bit | output | 1 | Last sampled slot bit |
| rd_byte | output | 8 | Last byte sampled |

## Verification
A wrong phase state or tick count shows up at once on pd_en. The pulldown edge moves by whole ticks, and pd_en is compared with the reference on every clock, so the miscompare appears on the first misplaced edge. A fault in the sampling point or the shift register cannot be seen on the waveform. It shows only in presence, short_det, rd_bit or rd_byte once busy falls, so the bench drives slave responses whose level changes close to each sampling instant. A mistake in the pullup window or in strong-pullup arming shows on pu_en and spu_n within one tick of the release or completion edge.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int T_W     = 12;
  localparam int BYTE_W  = 8;
  localparam int TICK_NS = 250;

  typedef enum logic [2:0] {
    OP_RST   = 3'd0,
    OP_WBIT  = 3'd1,
    OP_RBIT  = 3'd2,
    OP_WBYTE = 3'd3,
    OP_RBYTE = 3'd4
  } op_t;

  localparam logic [2:0] OP_LAST = 3'd4;

  typedef struct packed {
    logic [T_W-1:0] rst_low;
    logic [T_W-1:0] rst_high;
    logic [T_W-1:0] pres_smp;
    logic [T_W-1:0] short_smp;
    logic [T_W-1:0] slot;
    logic [T_W-1:0] read_smp;
    logic [T_W-1:0] apu_on;
  } prof_t;

  function automatic logic [T_W-1:0] ns2tk(input int ns);
    return T_W'((ns + TICK_NS / 2) / TICK_NS);
  endfunction

  function automatic prof_t speed_profile(input logic od);
    prof_t p;
    p.rst_low   = od ? ns2tk(72000) : ns2tk(600000);
    p.rst_high  = od ? ns2tk(74000) : ns2tk(584000);
    p.pres_smp  = od ? ns2tk(7500)  : ns2tk(70000);
    p.short_smp = od ? ns2tk(750)   : ns2tk(8000);
    p.slot      = od ? ns2tk(10500) : ns2tk(69300);
    p.read_smp  = od ? ns2tk(1500)  : ns2tk(14000);
    p.apu_on    = od ? ns2tk(500)   : ns2tk(2500);
    return p;
  endfunction

  // low time at the start of a slot: short for a one or a read, long for a zero
  function automatic logic [T_W-1:0] low_len(input logic od, input logic one);
    if (one) return od ? ns2tk(1000) : ns2tk(8000);
    return od ? ns2tk(7500) : ns2tk(64000);
  endfunction
endpackage

// File: rtl/ow_timebase.sv
module ow_timebase #(
  parameter int CLK_PER_TICK = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_TICK - 1);

  logic [PRE_W-1:0] pre_q, pre_n;

  assign tick = (pre_q == PRE_MAX);

  always_comb begin
    if (restart || tick) pre_n = '0;
    else                 pre_n = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end
endmodule

// File: rtl/ow_seq.sv
module ow_seq
  import ow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              accept,
  input  op_t               op,
  input  logic [BYTE_W-1:0] data,
  input  logic              od,
  input  logic              line_in,
  output logic              pd_en,
  output logic              busy,
  output logic              release_p,
  output logic              done_p,
  output logic [T_W-1:0]    apu_len,
  output logic              presence,
  output logic              short_det,
  output logic              rd_bit,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RLOW, ST_RHIGH, ST_SLOT} st_t;

  st_t               st_q, st_n;
  logic [T_W-1:0]    tcnt_q, tcnt_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              byte_q, byte_n;
  logic              od_q, od_n;
  logic              pd_q, pd_n;
  logic              pres_q, pres_n;
  logic              shrt_q, shrt_n;
  logic              rbit_q, rbit_n;
  logic [BYTE_W-1:0] rbyte_q, rbyte_n;
  prof_t             pf;

  assign pf = speed_profile(od_q);

  always_comb begin
    st_n    = st_q;
    tcnt_n  = tcnt_q;
    left_n  = left_q;
    sh_n    = sh_q;
    byte_n  = byte_q;
    od_n    = od_q;
    pres_n  = pres_q;
    shrt_n  = shrt_q;
    rbit_n  = rbit_q;
    rbyte_n = rbyte_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          od_n   = od;
          tcnt_n = '0;
          unique case (op)
            OP_RST: begin
              st_n   = ST_RLOW;
              pres_n = 1'b0;
              shrt_n = 1'b0;
            end
            OP_WBIT: begin
              st_n   = ST_SLOT;
              left_n = CNT_W'(1);
              byte_n = 1'b0;
              sh_n   = {{(BYTE_W-1){1'b1}}, data[0]};
            end
            OP_RBIT: begin
              st_n   = ST_SLOT;
              left_n = CNT_W'(1);
              byte_n = 1'b0;
              sh_n   = '1;
            end
            OP_WBYTE: begin
              st_n   = ST_SLOT;
              left_n = CNT_W'(BYTE_W);
              byte_n = 1'b1;
              sh_n   = data;
            end
            OP_RBYTE: begin
              st_n   = ST_SLOT;
              left_n = CNT_W'(BYTE_W);
              byte_n = 1'b1;
              sh_n   = '1;
            end
            default: st_n = ST_IDLE;
          endcase
        end
      end
      ST_RLOW: begin
        if (tick) begin
          if (tcnt_q == pf.rst_low - 1'b1) begin
            st_n   = ST_RHIGH;
            tcnt_n = '0;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
      end
      ST_RHIGH: begin
        if (tick) begin
          if (tcnt_q == pf.short_smp - 1'b1) shrt_n = ~line_in;
          if (tcnt_q == pf.pres_smp - 1'b1)  pres_n = ~line_in;
          if (tcnt_q == pf.rst_high - 1'b1) begin
            st_n   = ST_IDLE;
            tcnt_n = '0;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
      end
      ST_SLOT: begin
        if (tick) begin
          if (tcnt_q == pf.read_smp - 1'b1) begin
            rbit_n = line_in;
            if (byte_q) rbyte_n = {line_in, rbyte_q[BYTE_W-1:1]};
          end
          if (tcnt_q == pf.slot - 1'b1) begin
            tcnt_n = '0;
            sh_n   = {1'b1, sh_q[BYTE_W-1:1]};
            left_n = left_q - 1'b1;
            if (left_q == CNT_W'(1)) st_n = ST_IDLE;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    pd_n = (st_n == ST_RLOW) ||
           ((st_n == ST_SLOT) && (tcnt_n < low_len(od_n, sh_n[0])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      left_q  <= '0;
      sh_q    <= '1;
      byte_q  <= 1'b0;
      od_q    <= 1'b0;
      pd_q    <= 1'b0;
      pres_q  <= 1'b0;
      shrt_q  <= 1'b0;
      rbit_q  <= 1'b0;
      rbyte_q <= '0;
    end else begin
      st_q    <= st_n;
      tcnt_q  <= tcnt_n;
      left_q  <= left_n;
      sh_q    <= sh_n;
      byte_q  <= byte_n;
      od_q    <= od_n;
      pd_q    <= pd_n;
      pres_q  <= pres_n;
      shrt_q  <= shrt_n;
      rbit_q  <= rbit_n;
      rbyte_q <= rbyte_n;
    end
  end

  assign pd_en     = pd_q;
  assign busy      = (st_q != ST_IDLE);
  assign release_p = pd_q & ~pd_n;
  assign done_p    = (st_q != ST_IDLE) && (st_n == ST_IDLE);
  assign apu_len   = pf.apu_on;
  assign presence  = pres_q;
  assign short_det = shrt_q;
  assign rd_bit    = rbit_q;
  assign rd_byte   = rbyte_q;
endmodule

// File: rtl/ow_pullup.sv
module ow_pullup
  import ow_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           accept,
  input  logic           cfg_apu,
  input  logic           cfg_spu,
  input  logic           release_p,
  input  logic           done_p,
  input  logic [T_W-1:0] apu_len,
  output logic           pu_en,
  output logic           spu_n
);
  logic           apu_q, apu_n;
  logic           arm_q, arm_n;
  logic           act_q, act_n;
  logic [T_W-1:0] cnt_q, cnt_n;
  logic           spu_q, spu_d;

  always_comb begin
    apu_n = apu_q;
    arm_n = arm_q;
    act_n = act_q;
    cnt_n = cnt_q;
    spu_d = spu_q;
    if (accept) begin
      apu_n = cfg_apu;
      arm_n = cfg_spu;
      spu_d = 1'b0;
    end else if (done_p && arm_q) begin
      spu_d = 1'b1;
    end
    if (release_p && apu_q) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else if (act_q && tick) begin
      if (cnt_q == apu_len - 1'b1) act_n = 1'b0;
      else                         cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apu_q <= 1'b0;
      arm_q <= 1'b0;
      act_q <= 1'b0;
      cnt_q <= '0;
      spu_q <= 1'b0;
    end else begin
      apu_q <= apu_n;
      arm_q <= arm_n;
      act_q <= act_n;
      cnt_q <= cnt_n;
      spu_q <= spu_d;
    end
  end

  assign pu_en = act_q | spu_q;
  assign spu_n = ~spu_q;
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int CLK_PER_TICK = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              cfg_overdrive,
  input  logic              cfg_active_pu,
  input  logic              cfg_strong_pu,
  input  logic              line_in,
  output logic              pd_en,
  output logic              pu_en,
  output logic              spu_n,
  output logic              busy,
  output logic              presence,
  output logic              short_det,
  output logic              rd_bit,
  output logic [BYTE_W-1:0] rd_byte
);
  logic           rst_meta, rst_s;
  logic           tick, accept, release_p, done_p;
  logic [T_W-1:0] apu_len;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  assign accept = cmd_valid && !busy && (cmd_op <= OP_LAST);

  ow_timebase #(.CLK_PER_TICK(CLK_PER_TICK)) u_tb (
    .clk     (clk),
    .rst_n   (rst_s),
    .restart (accept),
    .tick    (tick)
  );

  ow_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_s),
    .tick      (tick),
    .accept    (accept),
    .op        (op_t'(cmd_op)),
    .data      (cmd_data),
    .od        (cfg_overdrive),
    .line_in   (line_in),
    .pd_en     (pd_en),
    .busy      (busy),
    .release_p (release_p),
    .done_p    (done_p),
    .apu_len   (apu_len),
    .presence  (presence),
    .short_det (short_det),
    .rd_bit    (rd_bit),
    .rd_byte   (rd_byte)
  );

  ow_pullup u_pu (
    .clk       (clk),
    .rst_n     (rst_s),
    .tick      (tick),
    .accept    (accept),
    .cfg_apu   (cfg_active_pu),
    .cfg_spu   (cfg_strong_pu),
    .release_p (release_p),
    .done_p    (done_p),
    .apu_len   (apu_len),
    .pu_en     (pu_en),
    .spu_n     (spu_n)
  );
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       pd_en,
  input logic       pu_en,
  input logic       spu_n,
  input logic       busy,
  input logic       presence,
  input logic       short_det
);
  logic acc;
  assign acc = cmd_valid && !busy && (cmd_op <= 3'd4);

  a_r7_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_en && pu_en));

  a_r9_pd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> busy);

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pd_en);

  a_r8_spu_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !spu_n |-> (pu_en && !busy));

  a_r8_spu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!spu_n && !acc) |=> !spu_n);

  a_r3_flags_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(acc && cmd_op == 3'd0)) |=> ($stable(presence) && $stable(short_det)));
endmodule

bind ow_master ow_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .pd_en     (pd_en),
  .pu_en     (pu_en),
  .spu_n     (spu_n),
  .busy      (busy),
  .presence  (presence),
  .short_det (short_det)
);

// File: tb/test_ow_master.sv
module test_ow_master;
  localparam int K = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;
  logic       cfg_overdrive, cfg_active_pu, cfg_strong_pu;
  logic       line_in;
  logic       pd_en, pu_en, spu_n, busy, presence, short_det, rd_bit;
  logic [7:0] rd_byte;

  always #5 clk = ~clk;

  ow_master #(.CLK_PER_TICK(K)) i_ow_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cfg_overdrive(cfg_overdrive),
    .cfg_active_pu(cfg_active_pu), .cfg_strong_pu(cfg_strong_pu),
    .line_in(line_in), .pd_en(pd_en), .pu_en(pu_en), .spu_n(spu_n),
    .busy(busy), .presence(presence), .short_det(short_det),
    .rd_bit(rd_bit), .rd_byte(rd_byte)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // slave behaviour selected by the stimulus: 0 silent, 1 presence pulse, 2 line shorted
  int       s_mode;
  logic [7:0] s_slv;

  // reference model state
  int RL, RH, MSP, SI, SL, W1, W0, MSR, APU;
  bit  acc_next, a_od, a_apu, a_spu;
  int  a_op, a_mode;
  logic [7:0] a_data, a_slv;
  bit  m_run, m_busy, m_apu, m_arm, m_spu, prev_pd;
  int  m_op, m_t, m_total, m_mode, apu_left;
  logic [7:0] m_wr, m_slv;
  bit  x_pres, x_short, x_rbit;
  logic [7:0] x_rbyte;

  function automatic int tk(input int ns);
    return (ns + 125) / 250;
  endfunction

  task automatic set_prof(input bit od);
    RL  = od ? tk(72000) : tk(600000);
    RH  = od ? tk(74000) : tk(584000);
    MSP = od ? tk(7500)  : tk(70000);
    SI  = od ? tk(750)   : tk(8000);
    SL  = od ? tk(10500) : tk(69300);
    W1  = od ? tk(1000)  : tk(8000);
    W0  = od ? tk(7500)  : tk(64000);
    MSR = od ? tk(1500)  : tk(14000);
    APU = od ? tk(500)   : tk(2500);
  endtask

  function automatic bit f_pd(input int t);
    int s, u;
    if (m_op == 0) return t < RL * K;
    s = t / (SL * K);
    u = t % (SL * K);
    return u < (m_wr[s] ? W1 : W0) * K;
  endfunction

  function automatic bit f_pull(input int t);
    int s, u;
    if (m_mode == 2) return 1'b1;
    if (m_op == 0)
      return (m_mode == 1) && (t >= (RL + SI + 2) * K) && (t < (RL + MSP + 20) * K);
    s = t / (SL * K);
    u = t % (SL * K);
    return !m_slv[s] && (u < (MSR + 4) * K);
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_pd, e_pu, pull;
    if (!rst_n) begin
      m_run = 0; m_busy = 0; m_spu = 0; m_arm = 0; m_apu = 0;
      prev_pd = 0; apu_left = 0; acc_next = 0; line_in = 1'b1;
      x_pres = 0; x_short = 0; x_rbit = 0; x_rbyte = 8'h00;
    end else begin
      if (acc_next) begin
        acc_next = 0;
        m_op = a_op; m_mode = a_mode; m_apu = a_apu; m_arm = a_spu;
        m_spu = 0; m_t = 0; m_run = 1;
        set_prof(a_od);
        m_slv = (a_op == 2 || a_op == 4) ? a_slv : 8'hFF;
        case (a_op)
          1: m_wr = {7'h7F, a_data[0]};
          3: m_wr = a_data;
          default: m_wr = 8'hFF;
        endcase
        if (a_op == 0) begin
          m_total = (RL + RH) * K;
          x_pres = 0; x_short = 0;
        end else begin
          m_total = ((a_op >= 3) ? 8 : 1) * SL * K;
        end
      end else if (m_run) begin
        m_t++;
      end
      if (m_run && m_t >= m_total) begin
        m_run = 0;
        if (m_op == 0) begin
          x_pres  = (m_mode != 0);
          x_short = (m_mode == 2);
        end else begin
          for (int s = 0; s < ((m_op >= 3) ? 8 : 1); s++) begin
            x_rbit = m_wr[s] & m_slv[s];
            if (m_op >= 3) x_rbyte[s] = x_rbit;
          end
        end
        if (m_arm) m_spu = 1;
      end
      m_busy = m_run;
      e_pd = m_busy ? f_pd(m_t) : 1'b0;
      if (prev_pd && !e_pd && m_apu) apu_left = APU * K;
      e_pu = (apu_left > 0) || m_spu;
      if (apu_left > 0) apu_left--;
      prev_pd = e_pd;
      // per-clock waveform comparison
      n_vec++;
      if (pd_en !== e_pd || pu_en !== e_pu || spu_n !== !m_spu || busy !== m_busy) begin
        n_bad++;
        $display("FAIL %s t=%0d: pd/pu/spu_n/busy actual %b%b%b%b expected %b%b%b%b",
                 (m_op == 0) ? "R2 R7 R8 R9" : "R5 R7 R8 R9", m_t,
                 pd_en, pu_en, spu_n, busy, e_pd, e_pu, !m_spu, m_busy);
      end
      pull = m_busy && f_pull(m_t);
      line_in = ~(e_pd | pull);
      if (cmd_valid && !m_busy && cmd_op <= 3'd4) begin
        acc_next = 1;
        a_op = cmd_op; a_data = cmd_data; a_od = cfg_overdrive;
        a_apu = cfg_active_pu; a_spu = cfg_strong_pu;
        a_mode = s_mode; a_slv = s_slv;
      end
    end
  end

  task automatic issue(input int op, input logic [7:0] d, input bit od,
                       input bit apu, input bit spu, input int mode, input logic [7:0] slv);
    @(posedge clk); #1;
    s_mode = mode; s_slv = slv;
    cmd_op = 3'(op); cmd_data = d; cfg_overdrive = od;
    cfg_active_pu = apu; cfg_strong_pu = spu; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic run(input int op, input logic [7:0] d, input bit od, input bit apu,
                     input bit spu, input int mode, input logic [7:0] slv, input int poke);
    issue(op, d, od, apu, spu, mode, slv);
    repeat (3) @(posedge clk);
    if (poke > 0) begin
      repeat (poke) @(posedge clk);
      #1; cmd_op = 3'd3; cmd_data = 8'h00; cmd_valid = 1'b1;   // R9: must be ignored
      @(posedge clk); #1; cmd_valid = 1'b0;
    end
    while (m_busy) @(posedge clk);
    @(negedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 8'h00;
    cfg_overdrive = 0; cfg_active_pu = 0; cfg_strong_pu = 0;
    s_mode = 0; s_slv = 8'hFF;
    repeat (5) @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    cmp("R1 pd_en", 8'(pd_en), 8'h0);
    cmp("R1 pu_en", 8'(pu_en), 8'h0);
    cmp("R1 spu_n", 8'(spu_n), 8'h1);
    cmp("R1 busy", 8'(busy), 8'h0);
    cmp("R1 presence", 8'(presence), 8'h0);
    cmp("R1 short_det", 8'(short_det), 8'h0);
    cmp("R1 rd_bit", 8'(rd_bit), 8'h0);
    cmp("R1 rd_byte", rd_byte, 8'h00);

    run(0, 8'h00, 0, 1, 0, 1, 8'hFF, 0);
    cmp("R3 presence std", 8'(presence), 8'(x_pres));
    cmp("R4 no short std", 8'(short_det), 8'(x_short));
    run(0, 8'h00, 0, 0, 0, 0, 8'hFF, 0);
    cmp("R3 presence cleared", 8'(presence), 8'(x_pres));
    run(0, 8'h00, 0, 1, 0, 2, 8'hFF, 0);
    cmp("R4 short std", 8'(short_det), 8'(x_short));
    cmp("R4 presence with short", 8'(presence), 8'(x_pres));
    run(0, 8'h00, 1, 1, 0, 1, 8'hFF, 0);
    cmp("R11 R3 presence od", 8'(presence), 8'(x_pres));
    cmp("R11 R4 no short od", 8'(short_det), 8'(x_short));

    run(1, 8'h01, 0, 1, 0, 0, 8'hFF, 0);
    cmp("R5 write one rd_bit", 8'(rd_bit), 8'(x_rbit));
    run(1, 8'h00, 0, 1, 0, 0, 8'hFF, 0);
    cmp("R5 write zero rd_bit", 8'(rd_bit), 8'(x_rbit));
    run(2, 8'h00, 0, 0, 0, 0, 8'hFE, 0);
    cmp("R5 read zero rd_bit", 8'(rd_bit), 8'(x_rbit));
    run(2, 8'h00, 1, 1, 0, 0, 8'hFF, 0);
    cmp("R11 R5 read one od", 8'(rd_bit), 8'(x_rbit));
    cmp("R5 bit op keeps rd_byte", rd_byte, x_rbyte);

    run(3, 8'hA5, 0, 1, 0, 0, 8'hFF, 0);
    cmp("R6 write byte std", rd_byte, x_rbyte);
    cmp("R6 last bit", 8'(rd_bit), 8'(x_rbit));
    run(4, 8'h00, 1, 0, 0, 0, 8'h3C, 0);
    cmp("R6 read byte od", rd_byte, x_rbyte);

    run(3, 8'h96, 1, 1, 1, 0, 8'hFF, 0);
    cmp("R8 strong on spu_n", 8'(spu_n), 8'h0);
    cmp("R8 strong on pu_en", 8'(pu_en), 8'h1);
    repeat (40) @(posedge clk);
    #1;
    cmp("R8 strong held", 8'(spu_n), 8'h0);
    cmd_op = 3'd6; cmd_valid = 1'b1;
    @(posedge clk); #1; cmd_valid = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    cmp("R10 invalid op no busy", 8'(busy), 8'h0);
    cmp("R10 invalid op keeps strong", 8'(spu_n), 8'h0);

    run(2, 8'h00, 0, 0, 0, 0, 8'hFF, 0);
    cmp("R8 strong released", 8'(spu_n), 8'h1);
    run(0, 8'h00, 1, 0, 0, 0, 8'hFF, 20);
    cmp("R9 poke ignored rd_byte", rd_byte, x_rbyte);
    cmp("R9 poke ignored presence", 8'(presence), 8'(x_pres));
    repeat (10) @(posedge clk);
    @(negedge clk); #1;
    cmp("R9 idle after poke", 8'(busy), 8'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule